// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

This block sits between a set of level-sensitive interrupt lines and an interrupt controller that learns about events through memory stores. It keeps a live record of the interrupt levels in a readable level word. For each trigger request, it builds a 64-bit notification word and issues it as a single store on a valid/ready master port. The request carries a source number and a flag that says the source's pending/queued state has already been checked. The notification word is a programmable base offset combined with the source number by a bitwise OR.

Software programs the block through a simple word-addressed register port. All 64-bit registers use most-significant-first bit numbering: bit k of a register is vector index 63-k.

The register map uses these word addresses:

| Address | Register |
|---|---|
| 0 | control |
| 1 | interrupt control |
| 2 | event-page base |
| 3 | notification address |
| 4 | offset |
| 5 | level (read-only) |
| 6, 7 | undefined |

The block also drives these outputs:
- the store-EOI mode flag;
- the event-page geometry: page-size flag, mapping enable and base address;
- a one-cycle reset pulse for the per-source state logic.

Top module: `itn_gen`

## Requirements
- R1: After reset every register reads zero, `st_valid`, `src_rst`, `store_eoi`, `esb_page_64k` and `esb_map_en` are low, and `trig_ready` is high.
- R2: Level register (address 5) holds input N at most-significant-first bit N (vector index 63-N), one clock after the input changes; unused bits read zero.
- R3: When most-significant-first bit 0 (index 63) of the interrupt control register (address 1) is set, the level register holds its value. Any input change then raises `lvl_ignored` for one cycle, one clock after the change.
- R4: A write to address 1 with most-significant-first bit 1 (index 62) set raises `src_rst` for exactly the following cycle, and the whole written value is stored and read back.
- R5: An accepted trigger with a valid notification address produces `st_data` = (offset register >> 32) OR source number, with bit index 32 set when `trig_checked` was high. `st_valid` rises one clock after acceptance.
- R6: When index 0 of the notification address register (address 3) is clear, an accepted trigger issues no store and `trig_dropped` pulses one clock later.
- R7: The store address equals the notification address register with index 0 forced to zero.
- R8: In the event-page base register (address 2), index 62 drives `esb_page_64k` (64 KiB pages when set, 4 KiB otherwise). `esb_map_en` changes only when a write flips index 0. `esb_base` is the register with indices 62 and 0 cleared.
- R9: Most-significant-first bit 12 (index 51) of the control register (address 0) drives `store_eoi`.
- R10: A read of addresses 6 or 7 returns all ones with `reg_err` high; defined addresses return `reg_err` low.
- R11: While a store is pending, `trig_ready` is low. `st_addr` and `st_data` hold steady until `st_ready` is seen, and a waiting trigger is accepted only after the store completes.
- R12: Writes to the level register have no effect on its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data (combinational) |
| reg_err | output | 1 | Read of an undefined address |
| irq_lvl | input | NUM_SRC | Interrupt input levels |
| lvl_ignored | output | 1 | Level change ignored under the method bit |
| trig_valid | input | 1 | Trigger request valid |
| trig_ready | output | 1 | Trigger request accepted |
| trig_src | input | SRC_W | Trigger source number |
| trig_checked | input | 1 | Pending state already checked |
| st_valid | output | 1 | Notification store valid |
| st_ready | input | 1 | Notification store accepted |
| st_addr | output | 64 | Store address |
| st_data | output | 64 | Store data |
| trig_dropped | output | 1 | Trigger discarded, address not valid |
| src_rst | output | 1 | Reset pulse to source state logic |
| store_eoi | output | 1 | Store-EOI mode enable |
| esb_page_64k | output | 1 | Event page size is 64 KiB |
| esb_map_en | output | 1 | Event pages mapped |
| esb_base | output | 64 | Event page base address |

## Verification
The bench builds the block with its defaults: 20 sources, the offset taken from the upper 32 bits, and the checked flag at index 32. With 20 sources the highest input lands at index 44, so a full-ones pattern checks the upper boundary of the level word. The 5-bit source field overlaps set bits of a chosen offset, which tells an OR apart from an addition. Because the flag sits just above the offset field, a flag misplaced onto the offset shows up in the data. Holding `st_ready` low for several cycles while a second trigger waits exercises the backpressure path.

// File: rtl/itn_pkg.sv
package itn_pkg;
   localparam int RA_W = 3;
   localparam int DW   = 64;

   typedef enum logic [RA_W-1:0] {
      RG_CTRL   = 3'd0,
      RG_INTCTL = 3'd1,
      RG_ESB    = 3'd2,
      RG_NADDR  = 3'd3,
      RG_OFFS   = 3'd4,
      RG_LEVEL  = 3'd5
   } itn_reg_e;

   // most-significant-first bit numbers
   localparam int MB_METHOD = 0;
   localparam int MB_SRCRST = 1;
   localparam int MB_STEOI  = 12;
   localparam int MB_PG64K  = 1;
   localparam int MB_VALID  = 63;

   function automatic int vidx(input int mb);
      return DW - 1 - mb;
   endfunction
endpackage

// File: rtl/itn_level_track.sv
module itn_level_track #(
   parameter int NUM_SRC = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] irq_lvl,
   input  logic              method,
   output logic [63:0]       level_word,
   output logic              ignored
);
   logic [63:0]        in_word;
   logic [63:0]        level_q;
   logic [NUM_SRC-1:0] prev_q;
   logic               ign_q;

   for (genvar n = 0; n < 64; n++) begin : g_map
      if (n < NUM_SRC) begin : g_src
         assign in_word[63-n] = irq_lvl[n];
      end else begin : g_pad
         assign in_word[63-n] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= '0;
         prev_q  <= '0;
         ign_q   <= 1'b0;
      end else begin
         prev_q <= irq_lvl;
         ign_q  <= method && (irq_lvl != prev_q);
         if (!method) level_q <= in_word;
      end
   end

   assign level_word = level_q;
   assign ignored    = ign_q;
endmodule

// File: rtl/itn_regs.sv
module itn_regs
   import itn_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic            reg_rd,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   output logic            reg_err,
   input  logic [DW-1:0]   level_word,
   output logic            method,
   output logic            src_rst,
   output logic            store_eoi,
   output logic            esb_page_64k,
   output logic            esb_map_en,
   output logic [DW-1:0]   esb_base,
   output logic [DW-1:0]   naddr,
   output logic [DW-1:0]   offs
);
   localparam int IX_VALID = vidx(MB_VALID);
   localparam int IX_PG64K = vidx(MB_PG64K);

   logic [DW-1:0] ctrl_q, intctl_q, esb_q, naddr_q, offs_q;
   logic          srst_q, map_q;
   logic [DW-1:0] rd_val;
   logic          rd_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         intctl_q <= '0;
         esb_q    <= '0;
         naddr_q  <= '0;
         offs_q   <= '0;
         srst_q   <= 1'b0;
         map_q    <= 1'b0;
      end else begin
         srst_q <= 1'b0;
         if (reg_wr) begin
            case (itn_reg_e'(reg_addr))
               RG_CTRL:   ctrl_q <= reg_wdata;
               RG_INTCTL: begin
                  intctl_q <= reg_wdata;
                  srst_q   <= reg_wdata[vidx(MB_SRCRST)];
               end
               RG_ESB: begin
                  if (reg_wdata[IX_VALID] != esb_q[IX_VALID])
                     map_q <= reg_wdata[IX_VALID];
                  esb_q <= reg_wdata;
               end
               RG_NADDR:  naddr_q <= reg_wdata;
               RG_OFFS:   offs_q  <= reg_wdata;
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      rd_hit = 1'b1;
      case (itn_reg_e'(reg_addr))
         RG_CTRL:   rd_val = ctrl_q;
         RG_INTCTL: rd_val = intctl_q;
         RG_ESB:    rd_val = esb_q;
         RG_NADDR:  rd_val = naddr_q;
         RG_OFFS:   rd_val = offs_q;
         RG_LEVEL:  rd_val = level_word;
         default: begin
            rd_val = '1;
            rd_hit = 1'b0;
         end
      endcase
   end

   assign reg_rdata    = rd_val;
   assign reg_err      = reg_rd && !rd_hit;
   assign method       = intctl_q[vidx(MB_METHOD)];
   assign src_rst      = srst_q;
   assign store_eoi    = ctrl_q[vidx(MB_STEOI)];
   assign esb_page_64k = esb_q[IX_PG64K];
   assign esb_map_en   = map_q;
   assign esb_base     = esb_q & ~((DW'(1) << IX_PG64K) | (DW'(1) << IX_VALID));
   assign naddr        = naddr_q;
   assign offs         = offs_q;
endmodule

// File: rtl/itn_notify.sv
module itn_notify #(
   parameter int SRC_W       = 5,
   parameter int PQ_FLAG_BIT = 32,
   parameter int OFF_SHIFT   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_valid,
   output logic             trig_ready,
   input  logic [SRC_W-1:0] trig_src,
   input  logic             trig_checked,
   input  logic [63:0]      naddr,
   input  logic [63:0]      offs,
   output logic             st_valid,
   input  logic             st_ready,
   output logic [63:0]      st_addr,
   output logic [63:0]      st_data,
   output logic             trig_dropped
);
   localparam logic [63:0] PQ_FLAG = 64'(1) << PQ_FLAG_BIT;

   logic        vld_q, drop_q;
   logic [63:0] addr_q, data_q;
   logic        accept;
   logic [63:0] word;

   assign accept = trig_valid && !vld_q;
   assign word   = (offs >> OFF_SHIFT) | 64'(trig_src) | (trig_checked ? PQ_FLAG : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         drop_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         drop_q <= accept && !naddr[0];
         if (accept && naddr[0]) begin
            vld_q  <= 1'b1;
            addr_q <= {naddr[63:1], 1'b0};
            data_q <= word;
         end else if (vld_q && st_ready) begin
            vld_q <= 1'b0;
         end
      end
   end

   assign trig_ready   = !vld_q;
   assign st_valid     = vld_q;
   assign st_addr      = addr_q;
   assign st_data      = data_q;
   assign trig_dropped = drop_q;
endmodule

// File: rtl/itn_gen.sv
module itn_gen
   import itn_pkg::*;
#(
   parameter int NUM_SRC     = 20,
   parameter int PQ_FLAG_BIT = 32,
   parameter int OFF_SHIFT   = 32,
   localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [RA_W-1:0]    reg_addr,
   input  logic [DW-1:0]      reg_wdata,
   output logic [DW-1:0]      reg_rdata,
   output logic               reg_err,
   input  logic [NUM_SRC-1:0] irq_lvl,
   output logic               lvl_ignored,
   input  logic               trig_valid,
   output logic               trig_ready,
   input  logic [SRC_W-1:0]   trig_src,
   input  logic               trig_checked,
   output logic               st_valid,
   input  logic               st_ready,
   output logic [DW-1:0]      st_addr,
   output logic [DW-1:0]      st_data,
   output logic               trig_dropped,
   output logic               src_rst,
   output logic               store_eoi,
   output logic               esb_page_64k,
   output logic               esb_map_en,
   output logic [DW-1:0]      esb_base
);
   if (NUM_SRC < 1 || NUM_SRC > DW) begin : g_bad_src
      $error("itn_gen: NUM_SRC out of range");
   end
   if (PQ_FLAG_BIT < 0 || PQ_FLAG_BIT >= DW) begin : g_bad_pq
      $error("itn_gen: PQ_FLAG_BIT out of range");
   end
   if (OFF_SHIFT < 0 || OFF_SHIFT >= DW) begin : g_bad_off
      $error("itn_gen: OFF_SHIFT out of range");
   end

   logic [DW-1:0] level_word, naddr, offs;
   logic          method;

   itn_level_track #(.NUM_SRC(NUM_SRC)) u_level (
      .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .method(method),
      .level_word(level_word), .ignored(lvl_ignored)
   );

   itn_regs u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_err(reg_err), .level_word(level_word), .method(method),
      .src_rst(src_rst), .store_eoi(store_eoi), .esb_page_64k(esb_page_64k),
      .esb_map_en(esb_map_en), .esb_base(esb_base), .naddr(naddr), .offs(offs)
   );

   itn_notify #(.SRC_W(SRC_W), .PQ_FLAG_BIT(PQ_FLAG_BIT), .OFF_SHIFT(OFF_SHIFT)) u_notify (
      .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
      .trig_src(trig_src), .trig_checked(trig_checked), .naddr(naddr), .offs(offs),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
      .st_data(st_data), .trig_dropped(trig_dropped)
   );
endmodule

// File: rtl/itn_gen_chk.sv
module itn_gen_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        reg_rd,
   input logic [2:0]  reg_addr,
   input logic [63:0] reg_wdata,
   input logic [63:0] reg_rdata,
   input logic        reg_err,
   input logic        trig_ready,
   input logic        st_valid,
   input logic        st_ready,
   input logic [63:0] st_addr,
   input logic [63:0] st_data,
   input logic        trig_dropped,
   input logic        src_rst,
   input logic        esb_map_en
);
   a_r11_hold_store: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && !st_ready |=> st_valid && $stable(st_addr) && $stable(st_data));

   a_r11_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> !trig_ready);

   a_r7_addr_clean: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> st_addr[0] == 1'b0);

   a_r10_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> reg_rd && reg_rdata == '1);

   a_r4_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_rst) |-> $past(reg_wr && reg_addr == 3'd1 && reg_wdata[62]));

   a_r6_drop_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_dropped) |-> !st_valid);

   a_r8_map_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      esb_map_en != $past(esb_map_en) |-> $past(reg_wr && reg_addr == 3'd2));
endmodule

bind itn_gen itn_gen_chk i_itn_gen_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .reg_err(reg_err), .trig_ready(trig_ready), .st_valid(st_valid),
   .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
   .trig_dropped(trig_dropped), .src_rst(src_rst), .esb_map_en(esb_map_en)
);

// File: tb/test_itn_gen.sv
`timescale 1ns/1ps
module test_itn_gen;
   localparam int NS = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        reg_err;
   logic [NS-1:0] irq_lvl = '0;
   logic        lvl_ignored;
   logic        trig_valid = 1'b0, trig_checked = 1'b0;
   logic        trig_ready;
   logic [4:0]  trig_src = '0;
   logic        st_valid, st_ready = 1'b1;
   logic [63:0] st_addr, st_data, esb_base;
   logic        trig_dropped, src_rst, store_eoi, esb_page_64k, esb_map_en;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   itn_gen i_itn_gen (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_err(reg_err), .irq_lvl(irq_lvl), .lvl_ignored(lvl_ignored),
      .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_src(trig_src),
      .trig_checked(trig_checked), .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data), .trig_dropped(trig_dropped),
      .src_rst(src_rst), .store_eoi(store_eoi), .esb_page_64k(esb_page_64k),
      .esb_map_en(esb_map_en), .esb_base(esb_base)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [63:0] d, output logic e);
      reg_rd = 1'b1; reg_addr = a;
      #1;
      d = reg_rdata; e = reg_err;
      reg_rd = 1'b0;
   endtask

   task automatic pulse_trig(input logic [4:0] s, input logic c);
      @(negedge clk);
      trig_valid = 1'b1; trig_src = s; trig_checked = c;
      @(negedge clk);
      trig_valid = 1'b0;
   endtask

   task automatic t_reset;
      logic [63:0] d; logic e;
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d, e);
         chk("R1 reg zero", d, 64'h0);
      end
      chk("R1 idle outputs", {st_valid, src_rst, store_eoi, esb_page_64k, esb_map_en, trig_ready}, 64'h1);
   endtask

   task automatic t_level;
      logic [63:0] d; logic e;
      @(negedge clk); irq_lvl = 20'h80021;
      @(negedge clk); rd(3'd5, d, e);
      chk("R2 level 0/5/19", d, 64'h8400_1000_0000_0000);
      irq_lvl = 20'h80000;
      @(negedge clk); rd(3'd5, d, e);
      chk("R2 level 19 only", d, 64'h0000_1000_0000_0000);
      irq_lvl = '1;
      @(negedge clk); rd(3'd5, d, e);
      chk("R2 level all", d, 64'hFFFF_F000_0000_0000);
      wr(3'd5, 64'h0);
      rd(3'd5, d, e);
      chk("R12 level write ignored", d, 64'hFFFF_F000_0000_0000);
   endtask

   task automatic t_method;
      logic [63:0] d; logic e;
      wr(3'd1, 64'h8000_0000_0000_0000);
      @(negedge clk);
      chk("R3 no flag while stable", 64'(lvl_ignored), 64'h0);
      irq_lvl = 20'h00003;
      @(negedge clk);
      chk("R3 ignored flag", 64'(lvl_ignored), 64'h1);
      rd(3'd5, d, e);
      chk("R3 level frozen", d, 64'hFFFF_F000_0000_0000);
      @(negedge clk);
      chk("R3 flag one cycle", 64'(lvl_ignored), 64'h0);
      wr(3'd1, 64'h0);
      @(negedge clk); rd(3'd5, d, e);
      chk("R3 tracking resumed", d, 64'hC000_0000_0000_0000);
   endtask

   task automatic t_srcrst;
      logic [63:0] d; logic e;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 64'h4000_0000_0000_00AB;
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R4 pulse high", 64'(src_rst), 64'h1);
      @(negedge clk);
      chk("R4 pulse ends", 64'(src_rst), 64'h0);
      rd(3'd1, d, e);
      chk("R4 value stored", d, 64'h4000_0000_0000_00AB);
      wr(3'd1, 64'h0);
   endtask

   task automatic t_notify;
      wr(3'd3, 64'h0000_1234_5678_9001);
      wr(3'd4, 64'h0000_0200_DEAD_BEEF);
      pulse_trig(5'd5, 1'b0);
      chk("R5 store valid", 64'(st_valid), 64'h1);
      chk("R7 store addr", st_addr, 64'h0000_1234_5678_9000);
      chk("R5 data plain", st_data, 64'h0000_0000_0000_0205);
      @(negedge clk);
      chk("R11 store done", 64'(st_valid), 64'h0);
      pulse_trig(5'd19, 1'b1);
      chk("R5 data checked flag", st_data, 64'h0000_0001_0000_0213);
      wr(3'd4, 64'h0000_0105_0000_0000);
      pulse_trig(5'd3, 1'b0);
      chk("R5 data is OR", st_data, 64'h0000_0000_0000_0107);
   endtask

   task automatic t_drop;
      wr(3'd3, 64'h0000_1234_5678_9000);
      pulse_trig(5'd7, 1'b0);
      chk("R6 dropped pulse", 64'(trig_dropped), 64'h1);
      chk("R6 no store", 64'(st_valid), 64'h0);
      @(negedge clk);
      chk("R6 still no store", 64'(st_valid), 64'h0);
   endtask

   task automatic t_backpressure;
      wr(3'd3, 64'h0000_0000_0000_4001);
      wr(3'd4, 64'h0);
      @(negedge clk);
      st_ready = 1'b0; trig_valid = 1'b1; trig_src = 5'd9; trig_checked = 1'b0;
      @(negedge clk);
      chk("R11 first store", st_data, 64'h9);
      chk("R11 ready low", 64'(trig_ready), 64'h0);
      trig_src = 5'd12;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R11 held data", st_data, 64'h9);
         chk("R11 held valid", 64'(st_valid), 64'h1);
      end
      st_ready = 1'b1;
      @(negedge clk);
      chk("R11 drained", 64'(st_valid), 64'h0);
      chk("R11 ready back", 64'(trig_ready), 64'h1);
      @(negedge clk);
      trig_valid = 1'b0;
      chk("R11 waiting trigger taken", st_data, 64'hC);
      chk("R7 addr after stall", st_addr, 64'h4000);
      @(negedge clk);
   endtask

   task automatic t_esb;
      logic [63:0] d; logic e;
      wr(3'd2, 64'h4000_0000_1234_0001);
      chk("R8 64k page", 64'(esb_page_64k), 64'h1);
      chk("R8 map enabled", 64'(esb_map_en), 64'h1);
      chk("R8 base", esb_base, 64'h0000_0000_1234_0000);
      wr(3'd2, 64'h0000_0000_5678_0001);
      chk("R8 4k page", 64'(esb_page_64k), 64'h0);
      chk("R8 map kept", 64'(esb_map_en), 64'h1);
      wr(3'd2, 64'h0000_0000_5678_0000);
      chk("R8 map disabled", 64'(esb_map_en), 64'h0);
      rd(3'd2, d, e);
      chk("R8 readback", d, 64'h0000_0000_5678_0000);
   endtask

   task automatic t_eoi;
      wr(3'd0, 64'h0008_0000_0000_0000);
      chk("R9 store eoi on", 64'(store_eoi), 64'h1);
      wr(3'd0, 64'h0);
      chk("R9 store eoi off", 64'(store_eoi), 64'h0);
   endtask

   task automatic t_undef;
      logic [63:0] d; logic e;
      @(negedge clk);
      rd(3'd6, d, e);
      chk("R10 undef 6 data", d, '1);
      chk("R10 undef 6 err", 64'(e), 64'h1);
      rd(3'd7, d, e);
      chk("R10 undef 7 data", d, '1);
      chk("R10 undef 7 err", 64'(e), 64'h1);
      rd(3'd3, d, e);
      chk("R10 defined no err", 64'(e), 64'h0);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_level();
      t_method();
      t_srcrst();
      t_notify();
      t_drop();
      t_backpressure();
      t_esb();
      t_eoi();
      t_undef();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule